// File: doc/BRIEF.md
# Byte-Wide Peripheral Bus Sequencer

This block lets a processor control unit reach a small I/O controller over an 8-bit shared data bus. The bus carries a 6-bit address, a chip select, a write enable and an output enable. The host places a one-cycle request and the sequencer runs one of three transactions: a single-byte write, a single-byte read, or a 16-bit write that is split into two byte writes to a pair of neighbouring register addresses.

The peripheral latches write data on the falling edge of chip select AND write enable. For that reason a write is a fixed three-cycle transaction. Write enable is high only in the first cycle. Chip select, address and data stay driven through the cycle in which write enable drops.

A read holds chip select and output enable high for two cycles while the sequencer releases the data bus. The returned byte is sampled at the end of the second cycle. Busy covers the whole transaction. Done is a single-cycle pulse once everything has finished.

Top module: `pbusMaster`

## Requirements
- R1: After reset, busCs, busWe, busOe, busDataDrive, busy and done are low, and rdData is 0.
- R2: A byte write (reqKind 0) holds busCs high and busOe low for three consecutive cycles. busWe is high in the first of these cycles only. busAddr equals reqAddr and busDataOut equals reqData[7:0], unchanged, in all three cycles.
- R3: busDataDrive is high only during write cycles. It is never high while busOe is high.
- R4: A word write (reqKind 2) runs two back-to-back three-cycle writes, six cycles in all. The first sends reqData[15:8] to {reqAddr[5:1],1}. The second sends reqData[7:0] to {reqAddr[5:1],0}. Bit 0 of reqAddr is ignored.
- R5: A byte read (reqKind 1 or 3) holds busCs and busOe high with busWe low for two cycles. It captures busDataIn into rdData at the clock edge that ends the second cycle. rdData then holds that value until the next read.
- R6: busy is high in every transaction cycle. done is high for exactly one cycle, the cycle after the last transaction cycle, and busy is low in that cycle.
- R7: A request presented while busy is high is ignored. The running transaction continues unchanged, and no further transaction follows it.
- R8: With a peripheral that latches on the falling edge of busCs AND busWe, a 16-bit write to base 4 sets the LED word (address 5 holds bits 15:8, address 4 holds bits 7:0), and a write to base 6 sets the display word. A read at address low bits 0 returns buttons 7:0, at 1 returns a zero bit followed by buttons 14:8, and at any other value returns the switches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, one cycle |
| reqKind | input | 2 | 0 byte write, 1 or 3 byte read, 2 word write |
| reqAddr | input | 6 | Register address (base address for a word write) |
| reqData | input | 16 | Write data |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rdData | output | 8 | Last byte read |
| busAddr | output | 6 | Bus address |
| busCs | output | 1 | Chip select |
| busWe | output | 1 | Write enable |
| busOe | output | 1 | Output enable |
| busDataOut | output | 8 | Byte driven onto the shared bus |
| busDataDrive | output | 1 | High when the sequencer drives the data bus |
| busDataIn | input | 8 | Resolved value of the shared data bus |

## Verification
The hardest situation to reach is a request that arrives while busy is high, at the seam where write enable has just fallen or partway through a read. An ignored start that leaked through would show up only as an extra transaction after done. The bench therefore injects a second request in the middle of a running write and of a running read. It then checks the strobes cycle by cycle and confirms that the bus stays idle after done. A scoreboard that expects exactly one done per accepted request catches any stray completion.

// File: rtl/pbusPkg.sv
package pbusPkg;
  typedef enum logic [1:0] {
    KIND_WRB = 2'd0,
    KIND_RDB = 2'd1,
    KIND_WRW = 2'd2,
    KIND_RDX = 2'd3
  } reqKind_e;

  typedef struct packed {
    logic cs;
    logic we;
    logic oe;
    logic drive;
    logic load;
    logic lowHalf;
    logic capture;
  } busCtl_t;
endpackage

// File: rtl/pbusCtrl.sv
module pbusCtrl
  import pbusPkg::*;
#(
  parameter int WR_CYCLES = 3,
  parameter int RD_CYCLES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqKind,
  output busCtl_t    ctl,
  output logic       busy,
  output logic       done
);
  localparam int MAX_CYC = (WR_CYCLES > RD_CYCLES) ? WR_CYCLES : RD_CYCLES;
  localparam int CNT_W = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
  localparam logic [CNT_W-1:0] WR_LAST = CNT_W'(WR_CYCLES - 1);
  localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(RD_CYCLES - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_WRITE, ST_READ} state_e;

  state_e           state;
  logic [CNT_W-1:0] cyc;
  logic             wordReq;
  logic             lowHalf;
  logic             doneQ;
  logic             accept;

  assign accept = reqValid && (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cyc     <= '0;
      wordReq <= 1'b0;
      lowHalf <= 1'b0;
      doneQ   <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            cyc     <= '0;
            lowHalf <= 1'b0;
            wordReq <= (reqKind == KIND_WRW);
            if (reqKind == KIND_WRB || reqKind == KIND_WRW) state <= ST_WRITE;
            else state <= ST_READ;
          end
        end
        ST_WRITE: begin
          if (cyc == WR_LAST) begin
            cyc <= '0;
            if (wordReq && !lowHalf) begin
              lowHalf <= 1'b1;
            end else begin
              state <= ST_IDLE;
              doneQ <= 1'b1;
            end
          end else begin
            cyc <= cyc + 1'b1;
          end
        end
        ST_READ: begin
          if (cyc == RD_LAST) begin
            cyc   <= '0;
            state <= ST_IDLE;
            doneQ <= 1'b1;
          end else begin
            cyc <= cyc + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl         = '0;
    ctl.load    = accept;
    ctl.lowHalf = lowHalf;
    case (state)
      ST_WRITE: begin
        ctl.cs    = 1'b1;
        ctl.drive = 1'b1;
        ctl.we    = (cyc == '0);
      end
      ST_READ: begin
        ctl.cs      = 1'b1;
        ctl.oe      = 1'b1;
        ctl.capture = (cyc == RD_LAST);
      end
      default: ;
    endcase
  end

  assign busy = (state != ST_IDLE);
  assign done = doneQ;
endmodule

// File: rtl/pbusDatapath.sv
module pbusDatapath
  import pbusPkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  busCtl_t               ctl,
  input  logic [1:0]            reqKind,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic [2*DATA_W-1:0]   reqData,
  input  logic [DATA_W-1:0]     busDataIn,
  output logic [ADDR_W-1:0]     busAddr,
  output logic [DATA_W-1:0]     busDataOut,
  output logic [DATA_W-1:0]     rdData
);
  localparam int WORD_W = 2 * DATA_W;

  logic [ADDR_W-1:0] baseAddr;
  logic [WORD_W-1:0] wordData;
  logic              isWord;
  logic              unusedCtl;

  assign unusedCtl = ^{ctl.cs, ctl.we, ctl.oe, ctl.drive};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseAddr <= '0;
      wordData <= '0;
      isWord   <= 1'b0;
      rdData   <= '0;
    end else begin
      if (ctl.load) begin
        baseAddr <= reqAddr;
        wordData <= reqData;
        isWord   <= (reqKind == KIND_WRW);
      end
      if (ctl.capture) rdData <= busDataIn;
    end
  end

  assign busAddr    = isWord ? {baseAddr[ADDR_W-1:1], ~ctl.lowHalf} : baseAddr;
  assign busDataOut = (isWord && !ctl.lowHalf) ? wordData[WORD_W-1:DATA_W]
                                               : wordData[DATA_W-1:0];
endmodule

// File: rtl/pbusMaster.sv
module pbusMaster
  import pbusPkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 8,
  parameter int WR_CYCLES = 3,
  parameter int RD_CYCLES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic [1:0]          reqKind,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [2*DATA_W-1:0] reqData,
  output logic                busy,
  output logic                done,
  output logic [DATA_W-1:0]   rdData,
  output logic [ADDR_W-1:0]   busAddr,
  output logic                busCs,
  output logic                busWe,
  output logic                busOe,
  output logic [DATA_W-1:0]   busDataOut,
  output logic                busDataDrive,
  input  logic [DATA_W-1:0]   busDataIn
);
  busCtl_t ctl;

  pbusCtrl #(.WR_CYCLES(WR_CYCLES), .RD_CYCLES(RD_CYCLES)) ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .ctl(ctl), .busy(busy), .done(done)
  );

  pbusDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqKind(reqKind), .reqAddr(reqAddr),
    .reqData(reqData), .busDataIn(busDataIn), .busAddr(busAddr),
    .busDataOut(busDataOut), .rdData(rdData)
  );

  assign busCs        = ctl.cs;
  assign busWe        = ctl.we;
  assign busOe        = ctl.oe;
  assign busDataDrive = ctl.drive;
endmodule

// File: rtl/pbusChecker.sv
module pbusChecker #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              done,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busCs,
  input logic              busWe,
  input logic              busOe,
  input logic [DATA_W-1:0] busDataOut,
  input logic              busDataDrive
);
  p_we_with_cs_r2: assert property (@(posedge clk) disable iff (!rstN)
    busWe |-> (busCs && !busOe));

  p_we_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    busWe |=> !busWe);

  p_hold_on_we_fall_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busWe) |-> (busCs && busDataDrive && $stable(busAddr) && $stable(busDataOut)));

  p_no_contention_r3: assert property (@(posedge clk) disable iff (!rstN)
    busOe |-> !busDataDrive);

  p_drive_in_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    busDataDrive |-> (busCs && !busOe));

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && !busCs));

  p_cs_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    busCs |-> busy);
endmodule

bind pbusMaster pbusChecker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done), .busAddr(busAddr),
  .busCs(busCs), .busWe(busWe), .busOe(busOe), .busDataOut(busDataOut),
  .busDataDrive(busDataDrive)
);

// File: tb/pbusMaster_tb_top.sv
`timescale 1ns/1ps
module pbusMaster_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqKind = 2'd0;
  logic [5:0]  reqAddr = 6'd0;
  logic [15:0] reqData = 16'd0;
  logic        busy, done;
  logic [7:0]  rdData;
  logic [5:0]  busAddr;
  logic        busCs, busWe, busOe, busDataDrive;
  logic [7:0]  busDataOut;
  logic [7:0]  busDataIn;

  logic [14:0] buttons = 15'h0;
  logic [7:0]  switches = 8'h0;
  logic [15:0] ledReg = 16'h0;
  logic [15:0] dispReg = 16'h0;
  logic [7:0]  periphOut;
  logic        wrStrobe;

  int errors = 0;
  int checks = 0;
  logic [8:0] expQ[$];

  always #2.5 clk = ~clk;

  pbusMaster dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .reqAddr(reqAddr), .reqData(reqData), .busy(busy), .done(done),
    .rdData(rdData), .busAddr(busAddr), .busCs(busCs), .busWe(busWe),
    .busOe(busOe), .busDataOut(busDataOut), .busDataDrive(busDataDrive),
    .busDataIn(busDataIn)
  );

  // behavioural peripheral: read mux on the low two address bits
  always_comb begin
    case (busAddr[1:0])
      2'd0:    periphOut = buttons[7:0];
      2'd1:    periphOut = {1'b0, buttons[14:8]};
      default: periphOut = switches;
    endcase
  end

  // shared bus resolution
  always_comb begin
    if (busDataDrive) busDataIn = busDataOut;
    else if (busCs && busOe) busDataIn = periphOut;
    else busDataIn = 8'hzz;
  end

  assign wrStrobe = busCs & busWe;
  always @(negedge wrStrobe) begin
    case (busAddr)
      6'd4: ledReg[7:0]   <= busDataOut;
      6'd5: ledReg[15:8]  <= busDataOut;
      6'd6: dispReg[7:0]  <= busDataOut;
      6'd7: dispReg[15:8] <= busDataOut;
      default: ;
    endcase
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: one done per accepted request
  always @(negedge clk) begin
    if (rstN && done) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R7 stray done actual=1 expected=0");
      end else begin
        logic [8:0] item;
        item = expQ.pop_front();
        if (item[8]) chk("R5 rdData at done", {8'h0, rdData}, {8'h0, item[7:0]});
      end
    end
  end

  // driver: issue a request, check every bus cycle, optionally inject a busy-time request
  task automatic runTxn(input logic [1:0] kind, input logic [5:0] addr,
                        input logic [15:0] data, input bit inject,
                        input logic [7:0] expRd);
    bit isRead = (kind == 2'd1 || kind == 2'd3);
    bit isWord = (kind == 2'd2);
    int n = isRead ? 2 : (isWord ? 6 : 3);
    @(negedge clk);
    reqValid = 1'b1; reqKind = kind; reqAddr = addr; reqData = data;
    expQ.push_back({isRead, expRd});
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      reqValid = 1'b0;
      chk("R6 busy in txn", {15'h0, busy}, 16'h1);
      chk("R2 cs", {15'h0, busCs}, 16'h1);
      if (isRead) begin
        chk("R5 oe", {15'h0, busOe}, 16'h1);
        chk("R5 we low", {15'h0, busWe}, 16'h0);
        chk("R3 released in read", {15'h0, busDataDrive}, 16'h0);
        chk("R5 addr", {10'h0, busAddr}, {10'h0, addr});
      end else begin
        logic [5:0] ea;
        logic [7:0] ed;
        if (isWord) begin
          ea = (i < 3) ? {addr[5:1], 1'b1} : {addr[5:1], 1'b0};
          ed = (i < 3) ? data[15:8] : data[7:0];
        end else begin
          ea = addr;
          ed = data[7:0];
        end
        chk("R2 oe low", {15'h0, busOe}, 16'h0);
        chk("R2 we first only", {15'h0, busWe}, {15'h0, (i % 3) == 0});
        chk("R3 drive in write", {15'h0, busDataDrive}, 16'h1);
        chk(isWord ? "R4 addr" : "R2 addr", {10'h0, busAddr}, {10'h0, ea});
        chk(isWord ? "R4 data" : "R2 data", {8'h0, busDataOut}, {8'h0, ed});
      end
      if (inject && i == 0) begin
        reqValid = 1'b1; reqKind = isRead ? 2'd0 : 2'd1;
        reqAddr = 6'd4; reqData = 16'h00EE;
      end
    end
    @(negedge clk);
    reqValid = 1'b0;
    chk("R6 done pulse", {15'h0, done}, 16'h1);
    chk("R6 busy low at done", {15'h0, busy}, 16'h0);
    chk("R3 released at done", {15'h0, busDataDrive}, 16'h0);
    @(negedge clk);
    chk("R6 done one cycle", {15'h0, done}, 16'h0);
    chk("R7 no follow-on txn", {15'h0, busCs}, 16'h0);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 cs", {15'h0, busCs}, 16'h0);
    chk("R1 we", {15'h0, busWe}, 16'h0);
    chk("R1 oe", {15'h0, busOe}, 16'h0);
    chk("R1 drive", {15'h0, busDataDrive}, 16'h0);
    chk("R1 busy", {15'h0, busy}, 16'h0);
    chk("R1 done", {15'h0, done}, 16'h0);
    chk("R1 rdData", {8'h0, rdData}, 16'h0);
    rstN = 1'b1;

    runTxn(2'd0, 6'd4, 16'h00A5, 1'b0, 8'h0);
    runTxn(2'd0, 6'd5, 16'hFF3C, 1'b0, 8'h0);
    chk("R8 led byte writes", ledReg, 16'h3CA5);

    runTxn(2'd2, 6'd6, 16'h1234, 1'b0, 8'h0);
    chk("R8 display word", dispReg, 16'h1234);
    runTxn(2'd2, 6'd5, 16'hBEEF, 1'b0, 8'h0);
    chk("R4 base bit0 ignored, led word", ledReg, 16'hBEEF);

    buttons = 15'h5A3C; switches = 8'hC3;
    runTxn(2'd1, 6'd0, 16'h0, 1'b0, 8'h3C);
    runTxn(2'd1, 6'd1, 16'h0, 1'b0, 8'h5A);
    runTxn(2'd1, 6'd2, 16'h0, 1'b0, 8'hC3);
    runTxn(2'd3, 6'd3, 16'h0, 1'b0, 8'hC3);
    runTxn(2'd1, 6'h21, 16'h0, 1'b0, 8'h5A);
    buttons = 15'h7FFF;
    @(negedge clk);
    chk("R5 rdData holds", {8'h0, rdData}, 16'h005A);

    runTxn(2'd0, 6'd6, 16'h0077, 1'b1, 8'h0);
    chk("R7 write unaffected by injected read", dispReg, 16'h1277);
    runTxn(2'd1, 6'd0, 16'h0, 1'b1, 8'hFF);
    chk("R7 injected write ignored", ledReg, 16'hBEEF);

    repeat (4) @(negedge clk);
    chk("R6 scoreboard drained", 16'(expQ.size()), 16'h0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule